// File: doc/BRIEF.md
# Spread-Spectrum Switching Cycle Timer with Burst Skipping

This block turns a system clock into the switching-cycle timing of a current-mode power converter controller. A reloadable down-counter marks the start of every switching period. The period length is the nominal count for the selected frequency option plus an offset, and that offset walks up and down in a slow triangle. The result is a spread of the switching energy across neighbouring frequencies.

At each cycle start the gate output is raised, unless light-load (burst) mode is active. The on-time then ends at the first of two events: a current-sense comparator trip that arrives once the blanking and minimum on-time window has passed, or the maximum duty count for the current period.

Burst mode follows two comparator flags from the feedback path. One flag says feedback is below the burst threshold. The other says feedback is above that threshold plus its hysteresis. Burst mode only suppresses cycles that have not started yet; a pulse already on is never cut short. While burst mode is active, a flag tells the current-limit stage to use its reduced peak clamp.

All inputs are synchronous to `clk`. None of the inputs or outputs is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pjit_pwm_timer`

## Requirements
- R1: While enabled, `cyc_start` pulses for one clock at every period boundary. The distance between two successive pulses is exactly the current period length in clocks: the nominal count plus the current offset.
- R2: The offset starts at 0 and moves up after reset. It changes by the step size at every cycle start, including skipped cycles. It reverses direction when it reaches +deviation (going up) or -deviation (going down), so it sweeps a triangle between those limits.
- R3: With no trip, the gate stays high for exactly floor(P*DUTY_Q8/256) clocks, where P is that cycle's period. No pulse ever lasts longer than this.
- R4: A `cs_trip` that arrives while the gate has been high for fewer than L = max(BLANK_CYC, MIN_ON_CYC) clocks does not end the pulse. A trip held from the start of the cycle gives a pulse of exactly L clocks.
- R5: Suppose `cs_trip` is first sampled high at a rising edge at which the gate has been high for d clocks, with L <= d < the duty cap. The gate then falls at that edge, so the pulse lasts d clocks.
- R6: `fb_low`=1 at an edge sets burst mode. `fb_high`=1 clears it, and `fb_low` has priority when both are high. With both low, the state holds. `burst_active` shows the state one edge after the flags are sampled.
- R7: A cycle that starts while burst mode is active still produces `cyc_start` but no gate pulse.
- R8: Entering burst mode during a pulse leaves that pulse's width unchanged.
- R9: `burst_active` is high exactly when burst mode is active, so it selects the reduced peak current clamp.
- R10: When `sw_en` is sampled low, the gate is low and `cyc_start` is quiet after that edge. The first edge with `sw_en` high again produces `cyc_start`.
- R11: During reset, `gate`, `cyc_start` and `burst_active` are all 0.
- R12: `freq_sel`=0 selects the low-frequency option (BASE_A, DEV_A, STEP_A) and 1 selects the high-frequency option (BASE_B, DEV_B, STEP_B). It may change only while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Switching enable |
| freq_sel | input | 1 | Frequency option: 0 low, 1 high |
| cs_trip | input | 1 | Current-sense comparator trip |
| fb_low | input | 1 | Feedback below burst threshold |
| fb_high | input | 1 | Feedback above burst threshold plus hysteresis |
| gate | output | 1 | Power switch gate drive |
| cyc_start | output | 1 | One-clock strobe at each cycle start |
| burst_active | output | 1 | Burst mode active, selects reduced current clamp |

## Verification
A wrong modulation state shows up as a wrong distance between start strobes. This appears at the very next period boundary and persists through the whole triangle. A wrong on-time counter or duty cap shows up as a wrong gate width within the same cycle. A wrong burst state shows on `burst_active` one clock after the flags change, and as a missing or extra gate pulse at the next cycle start. Every period and every gate width is therefore compared against an arithmetic model of the triangle, the duty cap and the trip lockout.

// File: rtl/pjit_pkg.sv
package pjit_pkg;
  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DN = 1'b1} sweep_dir_t;
endpackage

// File: rtl/pjit_sweep.sv
module pjit_sweep #(
  parameter int W      = 16,
  parameter int BASE_A = 3333,
  parameter int DEV_A  = 224,
  parameter int STEP_A = 4,
  parameter int BASE_B = 1739,
  parameter int DEV_B  = 120,
  parameter int STEP_B = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         adv,
  output logic [W-1:0] period_o
);
  import pjit_pkg::*;
  localparam logic [W-1:0]        BA = W'(BASE_A);
  localparam logic [W-1:0]        BB = W'(BASE_B);
  localparam logic signed [W:0]   DA = (W+1)'(DEV_A);
  localparam logic signed [W:0]   DB = (W+1)'(DEV_B);
  localparam logic signed [W:0]   SA = (W+1)'(STEP_A);
  localparam logic signed [W:0]   SB = (W+1)'(STEP_B);

  logic signed [W:0] off_q;
  logic signed [W:0] dev_v;
  logic signed [W:0] step_v;
  logic [W-1:0]      base_v;

  assign dev_v    = sel ? DB : DA;
  assign step_v   = sel ? SB : SA;
  assign base_v   = sel ? BB : BA;
  assign period_o = base_v + off_q[W-1:0];

  generate
    if (DEV_A == 0 && DEV_B == 0) begin : g_fixed
      assign off_q = '0;
    end else begin : g_tri
      sweep_dir_t dir_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          off_q <= '0;
          dir_q <= SWEEP_UP;
        end else if (adv) begin
          if (dir_q == SWEEP_UP) begin
            if (off_q >= dev_v) begin
              dir_q <= SWEEP_DN;
              off_q <= off_q - step_v;
            end else begin
              off_q <= off_q + step_v;
            end
          end else begin
            if (off_q <= -dev_v) begin
              dir_q <= SWEEP_UP;
              off_q <= off_q + step_v;
            end else begin
              off_q <= off_q - step_v;
            end
          end
        end
      end

      // R2
      tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (off_q == $past(off_q) + $past(step_v)) ||
                (off_q == $past(off_q) - $past(step_v)));
    end
  endgenerate
endmodule

// File: rtl/pjit_period.sv
module pjit_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period_i,
  output logic         adv_o,
  output logic         start_o,
  output logic [W-1:0] per_q
);
  logic [W-1:0] cnt_q;

  assign adv_o = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
      per_q   <= '0;
    end else if (!en) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= period_i - W'(1);
      start_o <= 1'b1;
      per_q   <= period_i;
    end else begin
      cnt_q   <= cnt_q - W'(1);
      start_o <= 1'b0;
    end
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/pjit_burst.sv
module pjit_burst (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_low,
  input  logic fb_high,
  output logic burst_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       burst_q <= 1'b0;
    else if (fb_low)  burst_q <= 1'b1;
    else if (fb_high) burst_q <= 1'b0;
  end

  // R6
  burst_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_low |=> burst_q);
  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_low && !fb_high) |=> $stable(burst_q));
endmodule

// File: rtl/pjit_ontime.sv
module pjit_ontime #(
  parameter int W         = 16,
  parameter int DUTY_Q8   = 205,
  parameter int BLANK_CYC = 60,
  parameter int MIN_ON_CYC = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start_i,
  input  logic         burst_i,
  input  logic [W-1:0] per_i,
  input  logic         trip_i,
  output logic         gate_q
);
  localparam int           LOCK   = (BLANK_CYC > MIN_ON_CYC) ? BLANK_CYC : MIN_ON_CYC;
  localparam logic [W-1:0] LOCK_V = W'(LOCK);

  logic [W+7:0] prod;
  logic [W-1:0] max_on;
  logic [W-1:0] on_q;
  logic         end_now;

  assign prod    = {8'b0, per_i} * (W+8)'(DUTY_Q8);
  assign max_on  = prod[W+7:8];
  assign end_now = (on_q >= max_on) || (trip_i && on_q >= LOCK_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      on_q   <= '0;
    end else if (!en) begin
      gate_q <= 1'b0;
      on_q   <= '0;
    end else if (start_i) begin
      gate_q <= !burst_i;
      on_q   <= W'(1);
    end else if (gate_q) begin
      if (end_now) gate_q <= 1'b0;
      else         on_q   <= on_q + W'(1);
    end
  end

  // R3
  duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (on_q <= max_on));
  // R4
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate_q && !start_i && on_q < LOCK_V && on_q < max_on) |=> gate_q);
endmodule

// File: rtl/pjit_pwm_timer.sv
module pjit_pwm_timer #(
  parameter int W          = 16,
  parameter int BASE_A     = 3333,
  parameter int DEV_A      = 224,
  parameter int STEP_A     = 4,
  parameter int BASE_B     = 1739,
  parameter int DEV_B      = 120,
  parameter int STEP_B     = 1,
  parameter int DUTY_Q8    = 205,
  parameter int BLANK_CYC  = 60,
  parameter int MIN_ON_CYC = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic freq_sel,
  input  logic cs_trip,
  input  logic fb_low,
  input  logic fb_high,
  output logic gate,
  output logic cyc_start,
  output logic burst_active
);
  logic [W-1:0] period_nxt;
  logic [W-1:0] per_cur;
  logic         adv;
  logic         burst_q;

  pjit_sweep #(
    .W(W), .BASE_A(BASE_A), .DEV_A(DEV_A), .STEP_A(STEP_A),
    .BASE_B(BASE_B), .DEV_B(DEV_B), .STEP_B(STEP_B)
  ) u_sweep (
    .clk(clk), .rst_n(rst_n), .sel(freq_sel), .adv(adv), .period_o(period_nxt)
  );

  pjit_period #(.W(W)) u_period (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .period_i(period_nxt),
    .adv_o(adv), .start_o(cyc_start), .per_q(per_cur)
  );

  pjit_burst u_burst (
    .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .fb_high(fb_high), .burst_q(burst_q)
  );

  pjit_ontime #(
    .W(W), .DUTY_Q8(DUTY_Q8), .BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC)
  ) u_ontime (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .start_i(adv), .burst_i(burst_q),
    .per_i(per_cur), .trip_i(cs_trip), .gate_q(gate)
  );

  assign burst_active = burst_q;

  // R7
  gate_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> cyc_start);
  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (!gate && !cyc_start));
endmodule

// File: tb/pjit_pwm_timer_test.sv
module pjit_pwm_timer_test;
  localparam int W = 8;
  localparam int BA = 40, DA = 8, SA = 2;
  localparam int BB = 24, DB = 3, SB = 1;
  localparam int DQ = 205, BLK = 3, MON = 5;
  localparam int LCK = (BLK > MON) ? BLK : MON;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_en = 1'b0;
  logic freq_sel = 1'b0;
  logic cs_trip = 1'b0;
  logic fb_low = 1'b0;
  logic fb_high = 1'b0;
  logic gate, cyc_start, burst_active;

  int checks = 0;
  int fails = 0;
  int trip_at = 1000;
  int nstarts = 0;
  int cycles = 0;

  int  off_m = 0;
  bit  dn_m = 0;
  bit  bm = 0;
  bit  prev_en = 0;
  bit  in_win = 0;
  int  win_len = 0;
  int  win_g = 0;
  int  exp_len = 0;
  int  exp_w = 0;
  int  win_trip = 1000;
  bit  win_skip = 0;

  always #2.5 clk = ~clk;

  pjit_pwm_timer #(
    .W(W), .BASE_A(BA), .DEV_A(DA), .STEP_A(SA), .BASE_B(BB), .DEV_B(DB), .STEP_B(SB),
    .DUTY_Q8(DQ), .BLANK_CYC(BLK), .MIN_ON_CYC(MON)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .freq_sel(freq_sel), .cs_trip(cs_trip),
    .fb_low(fb_low), .fb_high(fb_high), .gate(gate), .cyc_start(cyc_start),
    .burst_active(burst_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int duty_cap(input int p);
    return (p * DQ) / 256;
  endfunction

  // Monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst_n) begin
      in_win = 0; bm = 0; off_m = 0; dn_m = 0; prev_en = 0;
      cs_trip = 1'b0;
    end else if (!sw_en) begin
      chk(!gate && !cyc_start, "R10 quiet while disabled", {gate, cyc_start}, 0);
      in_win = 0; prev_en = 0;
      bm = fb_low ? 1'b1 : (fb_high ? 1'b0 : bm);
      chk(burst_active == bm, "R6 burst state", burst_active, bm);
      cs_trip = 1'b0;
    end else begin
      bit bm_before;
      int p;
      if (!prev_en) chk(cyc_start, "R10 start on enable", cyc_start, 1);
      prev_en = 1;
      bm_before = bm;
      bm = fb_low ? 1'b1 : (fb_high ? 1'b0 : bm);
      chk(burst_active == bm, "R9 burst flag", burst_active, bm);
      if (cyc_start) begin
        if (in_win) begin
          string tag;
          chk(win_len == exp_len, "R1 period length", win_len, exp_len);
          if (win_skip) tag = "R7 skipped cycle";
          else if (bm) tag = "R8 no truncation";
          else if (win_trip < LCK) tag = "R4 blanked trip";
          else if (win_trip < 1000) tag = "R5 trip width";
          else tag = "R3 duty cap";
          chk(win_g == exp_w, tag, win_g, exp_w);
        end
        nstarts++;
        p = (freq_sel ? BB : BA) + off_m;
        // R2 triangle model
        if (!dn_m) begin
          if (off_m >= (freq_sel ? DB : DA)) begin dn_m = 1; off_m -= (freq_sel ? SB : SA); end
          else off_m += (freq_sel ? SB : SA);
        end else begin
          if (off_m <= -(freq_sel ? DB : DA)) begin dn_m = 0; off_m += (freq_sel ? SB : SA); end
          else off_m -= (freq_sel ? SB : SA);
        end
        exp_len  = p;
        win_trip = trip_at;
        win_skip = bm_before;
        if (bm_before) exp_w = 0;
        else begin
          exp_w = (win_trip > LCK) ? win_trip : LCK;
          if (exp_w > duty_cap(p)) exp_w = duty_cap(p);
        end
        in_win  = 1;
        win_len = 1;
        win_g   = gate ? 1 : 0;
      end else if (in_win) begin
        win_len++;
        win_g += gate ? 1 : 0;
      end
      cs_trip = in_win && (win_len >= win_trip);
    end
  end

  task automatic wait_starts(input int n);
    int tgt;
    tgt = nstarts + n;
    while (nstarts < tgt) @(negedge clk);
  endtask

  task automatic do_reset(input bit sel);
    @(negedge clk);
    rst_n = 0; sw_en = 0; freq_sel = sel; fb_low = 0; fb_high = 0;
    repeat (4) @(negedge clk);
    // R11
    chk(!gate && !cyc_start && !burst_active, "R11 reset state",
        {gate, cyc_start, burst_active}, 0);
    rst_n = 1;
    @(negedge clk);
    sw_en = 1;
  endtask

  initial begin
    do_reset(1'b0);
    // R1 R2 R3 R12: low option, two full triangles
    trip_at = 1000;
    wait_starts(34);
    // R4 R5: trip delay sweep
    for (int d = 0; d <= 30; d++) begin
      trip_at = d;
      wait_starts(1);
    end
    trip_at = 1000;
    wait_starts(2);
    // R8 R6 R7 R9: enter burst during a pulse
    while (!cyc_start) @(negedge clk);
    @(negedge clk); @(negedge clk);
    fb_low = 1;
    @(negedge clk);
    fb_low = 0;
    wait_starts(4);
    fb_high = 1;
    @(negedge clk);
    fb_high = 0;
    wait_starts(3);
    // R6: both flags high, low has priority
    fb_low = 1; fb_high = 1;
    @(negedge clk);
    fb_low = 0; fb_high = 0;
    wait_starts(2);
    fb_high = 1;
    @(negedge clk);
    fb_high = 0;
    wait_starts(2);
    // R10: disable mid pulse, then resume
    while (!cyc_start) @(negedge clk);
    @(negedge clk);
    sw_en = 0;
    repeat (12) @(negedge clk);
    sw_en = 1;
    wait_starts(3);
    // R12: high option, two full triangles
    do_reset(1'b1);
    wait_starts(30);
    trip_at = 7;
    wait_starts(3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule